// File: doc/BRIEF.md
# PHY Interrupt and Mode Register Unit

This unit holds two management-visible registers of a PHY: an interrupt register that pairs a byte of per-condition enables with a byte of latched event flags, and a mode register that sets the interrupt pin polarity and controls cable crossover selection. Event strobes from the PHY core set the flags. The flags stay set until the interrupt register is read, and that read clears them. The interrupt pin is asserted while any flag is set whose enable is also set.

The management slave reaches the unit through a plain register port. It presents a 5-bit register address with a write strobe or a read strobe. Read data is combinational from the addressed register and is zero for any other address. Register updates and read-clears take effect at the clock edge on which the strobe is sampled. The crossover output follows the cable-sense input unless software turns automatic selection off, in which case a register bit forces the mode.

Top module: `phy_irq_mode_regs`

## Requirements
- R1: Register 0x1B reads back with the eight enable bits in bits 15:8 and the eight latched event flags in bits 7:0. Flag i belongs to event input bit i, and enable i gates flag i.
- R2: A one on event input bit i at a clock edge sets flag i. The flag then stays set through later cycles until register 0x1B is read.
- R3: A read strobe to register 0x1B returns the current flags and clears all of them at that same edge, so a second read returns 0 in bits 7:0.
- R4: An event bit that is high in the same cycle as a read-clear of 0x1B leaves its flag set after that edge.
- R5: A write to register 0x1B updates only the enables from bits 15:8. Data in bits 7:0 has no effect on the flags.
- R6: The interrupt is active when any flag has its enable set. Flags whose enable is clear never make the interrupt active.
- R7: Bit 9 of register 0x1F selects the pin polarity. When it is 0, active means irq_o low and idle means irq_o high. When it is 1, active means irq_o high. Reset leaves it at 0.
- R8: After reset, automatic crossover is on and xover_o follows sense_cross_i (1 = crossover, 0 = straight).
- R9: When bit 13 of register 0x1F is 1, automatic crossover is off and xover_o equals bit 14 of 0x1F (1 = crossover, 0 = straight), whatever sense_cross_i is.
- R10: Register 0x1F resets to 0x0000, and every one of its 16 bits reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| reg_addr | input | 5 | Register address from the management slave |
| reg_wr | input | 1 | Write strobe for reg_addr |
| reg_rd | input | 1 | Read strobe for reg_addr; a read of 0x1B clears the flags |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register, 0 for other addresses |
| evt_i | input | 8 | Event strobes from the PHY core, one per flag |
| sense_cross_i | input | 1 | Cable-sense result: 1 = crossover, 0 = straight |
| irq_o | output | 1 | Interrupt pin with programmable polarity |
| xover_o | output | 1 | Selected cable mode: 1 = crossover, 0 = straight |

## Verification
Two functions can land on the same edge: a read-clear of the interrupt register and a new event strobe. The bench first sets one flag. It then raises a different event bit in the very cycle it issues the read. The returned word must show only the earlier flag, and a following read must show only the flag of the colliding event. A write of ones into the flag field is also checked to leave the flags untouched.

// File: rtl/phy_irq_mode_pkg.sv
package phy_irq_mode_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned N_EVT     = REG_W / 2;
  localparam logic [ADDR_W-1:0] ADDR_IRQ  = 5'h1B;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 5'h1F;
  localparam int unsigned BIT_POL      = 9;
  localparam int unsigned BIT_AUTO_OFF = 13;
  localparam int unsigned BIT_FORCE_X  = 14;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import phy_irq_mode_pkg::*;
#(
  parameter int unsigned NE = N_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_i,
  input  logic          wr_en_i,
  input  logic [NE-1:0] wr_en_data_i,
  input  logic          rd_clr_i,
  output logic [NE-1:0] en_o,
  output logic [NE-1:0] flag_o
);
  logic [NE-1:0] en_q, en_d;
  logic [NE-1:0] flag_q, flag_d;

  always_comb begin
    en_d = en_q;
    if (wr_en_i) en_d = wr_en_data_i;
  end

  always_comb begin
    if (rd_clr_i) flag_d = evt_i;
    else          flag_d = flag_q | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R2
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> ((flag_q & ~$past(evt_i)) == '0)); // R3
  AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && (evt_i != '0)) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_FLAG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rd_clr_i && (evt_i == '0)) |=> $stable(flag_q)); // R5
endmodule

// File: rtl/irq_mode_unit.sv
module irq_mode_unit
  import phy_irq_mode_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic         sense_i,
  output logic [W-1:0] mode_o,
  output logic         pol_high_o,
  output logic         xover_o
);
  logic [W-1:0] mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en_i) mode_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign mode_o     = mode_q;
  assign pol_high_o = mode_q[BIT_POL];
  assign xover_o    = mode_q[BIT_AUTO_OFF] ? mode_q[BIT_FORCE_X] : sense_i;

  AST_FORCED_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[BIT_AUTO_OFF] && $stable(mode_q)) |-> $stable(xover_o)); // R9
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i) |=> $stable(mode_q)); // R10
endmodule

// File: rtl/phy_irq_mode_regs.sv
module phy_irq_mode_regs
  import phy_irq_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              sense_cross_i,
  output logic              irq_o,
  output logic              xover_o
);
  logic              rst_ns;
  logic              sel_irq, sel_mode;
  logic [N_EVT-1:0]  en_w, flag_w;
  logic [REG_W-1:0]  mode_w;
  logic              pol_high;
  logic              irq_active;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  assign sel_irq  = (reg_addr == ADDR_IRQ);
  assign sel_mode = (reg_addr == ADDR_MODE);

  irq_flag_unit #(.NE(N_EVT)) u_flags (
    .clk          (clk),
    .rst_n        (rst_ns),
    .evt_i        (evt_i),
    .wr_en_i      (reg_wr && sel_irq),
    .wr_en_data_i (reg_wdata[REG_W-1:N_EVT]),
    .rd_clr_i     (reg_rd && sel_irq),
    .en_o         (en_w),
    .flag_o       (flag_w)
  );

  irq_mode_unit #(.W(REG_W)) u_mode (
    .clk        (clk),
    .rst_n      (rst_ns),
    .wr_en_i    (reg_wr && sel_mode),
    .wdata_i    (reg_wdata),
    .sense_i    (sense_cross_i),
    .mode_o     (mode_w),
    .pol_high_o (pol_high),
    .xover_o    (xover_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_irq)       reg_rdata = {en_w, flag_w};
    else if (sel_mode) reg_rdata = mode_w;
  end

  assign irq_active = |(en_w & flag_w);
  assign irq_o      = pol_high ? irq_active : ~irq_active;

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_ns)
    ((en_w & flag_w) == '0) |-> (irq_o == !mode_w[BIT_POL])); // R6
  AST_IRQ_POLARITY: assert property (@(posedge clk) disable iff (!rst_ns)
    ((en_w & flag_w) != '0) |-> (irq_o == mode_w[BIT_POL])); // R7
  AST_AUTO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_ns)
    (!mode_w[BIT_AUTO_OFF]) |-> (xover_o == sense_cross_i)); // R8
endmodule

// File: tb/phy_irq_mode_regs_tb.sv
module phy_irq_mode_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [7:0]  evt_i;
  logic        sense_cross_i;
  logic        irq_o, xover_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  phy_irq_mode_regs u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .evt_i         (evt_i),
    .sense_cross_i (sense_cross_i),
    .irq_o         (irq_o),
    .xover_o       (xover_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] ev, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1; evt_i = ev;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    sense_cross_i = 1'b1;
    #1;
    chk("R7 idle pin after reset", {15'd0, irq_o}, 16'd1);
    chk("R8 xover follows sense after reset", {15'd0, xover_o}, 16'd1);
    rd(5'h1F, 8'h00, d); chk("R10 mode reset value", d, 16'h0000);
    rd(5'h1B, 8'h00, d); chk("R1 irq reg reset value", d, 16'h0000);
  endtask

  task automatic t_latch();
    logic [15:0] d;
    pulse(8'h09);
    repeat (2) @(negedge clk);
    chk("R6 unenabled flags keep pin idle", {15'd0, irq_o}, 16'd1);
    rd(5'h1B, 8'h00, d); chk("R2 flags latched and held", d, 16'h0009);
    rd(5'h1B, 8'h00, d); chk("R3 flags cleared by read", d, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wr(5'h1B, 16'h84FF);
    rd(5'h1B, 8'h00, d); chk("R5 write leaves flags, R1 enables in 15:8", d, 16'h8400);
    pulse(8'h04);
    chk("R6 enabled flag asserts pin low", {15'd0, irq_o}, 16'd0);
    rd(5'h1B, 8'h00, d); chk("R1 enables and flag", d, 16'h8404);
    chk("R3 pin idle after read-clear", {15'd0, irq_o}, 16'd1);
    pulse(8'h01);
    chk("R6 flag without enable ignored", {15'd0, irq_o}, 16'd1);
    rd(5'h1B, 8'h00, d); chk("R2 unenabled flag latched", d, 16'h8401);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    pulse(8'h80);
    rd(5'h1B, 8'h04, d); chk("R4 read returns earlier flag", d, 16'h8480);
    chk("R4 colliding enabled event keeps pin active", {15'd0, irq_o}, 16'd0);
    rd(5'h1B, 8'h00, d); chk("R4 colliding event kept", d, 16'h8404);
  endtask

  task automatic t_polarity();
    logic [15:0] d;
    wr(5'h1F, 16'h0200);
    chk("R7 active-high idle low", {15'd0, irq_o}, 16'd0);
    pulse(8'h80);
    chk("R7 active-high asserted", {15'd0, irq_o}, 16'd1);
    rd(5'h1B, 8'h00, d);
    chk("R7 active-high released", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_xover();
    sense_cross_i = 1'b0; #1;
    chk("R8 follows sense straight", {15'd0, xover_o}, 16'd0);
    wr(5'h1F, 16'h6200);
    chk("R9 forced crossover", {15'd0, xover_o}, 16'd1);
    sense_cross_i = 1'b1; #1;
    wr(5'h1F, 16'h2200);
    chk("R9 forced straight ignores sense", {15'd0, xover_o}, 16'd0);
    wr(5'h1F, 16'h4200);
    chk("R8 auto again follows sense", {15'd0, xover_o}, 16'd1);
  endtask

  task automatic t_storage();
    logic [15:0] d;
    wr(5'h1F, 16'h9A5B);
    rd(5'h1F, 8'h00, d); chk("R10 mode storage", d, 16'h9A5B);
    wr(5'h1F, 16'h65A4);
    rd(5'h1F, 8'h00, d); chk("R10 mode storage inverse", d, 16'h65A4);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; evt_i = '0; sense_cross_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch();
    t_enable();
    t_collide();
    t_polarity();
    t_xover();
    t_storage();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule